// File: doc/BRIEF.md
# Vertical-Blank Interrupt Controller

This block gathers interrupt events into a 32-bit sticky status register and gates them with a 32-bit enable register. It drives one level-sensitive interrupt line, which stays high while any enabled status bit is set. Status bit 0 belongs to an internal vertical-blank source. That source is a free-running period counter, sized by default to fire sixty times a second from a 100 MHz clock. The other status bits are set by single-cycle pulses on a generic event input.

Software writes the enable register to choose which bits can raise the line. Setting the vblank enable bit raises the vblank status bit at once and restarts the period count from zero. Clearing the vblank enable bit halts the counter. Status bits are cleared by writing ones, but only bits that fall inside an elaboration-time clear mask respond to the write. Reads are plain, side-effect-free selections of either register.

Top module: `vbl_irq_ctrl`

## Requirements
- R1: While reset is low at a clock edge, both registers are cleared, the interrupt is low and the period counter is halted, so no vblank status appears afterwards until the enable register is written with bit 0 set.
- R2: `irq_o` is high exactly when at least one bit is set in both the status and the enable register.
- R3: A write with `wr_sel` = 0 stores `wr_data` in the enable register from the next cycle on.
- R4: An enable write with bit 0 set makes status bit 0 read as 1 in the following cycle, whatever its earlier value.
- R5: After an enable write with bit 0 set at edge E, the counter sets status bit 0 at edges E+PERIOD, E+2·PERIOD and so on. A new such write restarts this phase.
- R6: An enable write with bit 0 clear halts the counter, and the counter sets no further vblank status.
- R7: A write with `wr_sel` = 1 clears each status bit where `wr_data` AND `CLR_MASK` is 1. Bits outside `CLR_MASK` (default 0x000F040F: bits 0-3, 10 and 16-19) are left unchanged.
- R8: A one-cycle pulse on `evt_i[k]` sets status bit k, and the bit stays set after the pulse ends.
- R9: When a set (counter expiry or event pulse) and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R10: `rd_data` returns the enable register for `rd_sel` = 0 and the status register for `rd_sel` = 1. Reading changes no state.

Reset is synchronous and active low; `wr_sel` = 0 selects the enable register and `wr_sel` = 1 selects the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 enable, 1 status |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 enable, 1 status |
| rd_data | output | 32 | Selected register value |
| evt_i | input | 32 | Event pulses, one per status bit |
| irq_o | output | 1 | Level interrupt output |

## Verification
The checker watches a set of rules on every cycle. It checks the reset values and the write of the enable register. It checks that an enabling write raises both the vblank status and the line in the next cycle. It checks that a counter expiry always leaves bit 0 set, even when a clearing write lands in the same cycle. It also checks that event pulses always stick, that bits outside the mask never fall, and that a halted source never raises bit 0. Other behaviour can only be shown by the bench's scenarios against its reference model. This covers the exact period length and the phase restart, the masked clearing of chosen bits, the combined set-and-clear of an event bit, and the idle counter after reset and after a disable.

// File: rtl/vbl_irq_pkg.sv
// Shared definitions for the vertical-blank interrupt controller.
// Assumes a single-bit register select on both read and write paths.
package vbl_irq_pkg;
    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;

    // Status/enable bit owned by the vertical-blank source.
    localparam int VBL_BIT = 0;
endpackage

// File: rtl/vbl_period_timer.sv
// Periodic tick source: counts PERIOD cycles while running and pulses
// tick_o for one cycle on the last count. start_i restarts from zero,
// stop_i halts; start_i wins if both are asserted.
// Assumes PERIOD >= 2.
module vbl_period_timer #(
    parameter int PERIOD = 1_666_667
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    output logic tick_o
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    // Expiry is the final count of a running period.
    assign tick_o = run_q && (cnt_q == LAST);

    // Run flag and cycle counter with restart and halt control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (stop_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (run_q) begin
            cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/vbl_enable_reg.sv
// Plain enable register: loads the full word on a write strobe.
// Assumes the strobe is already decoded for this register.
module vbl_enable_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] en_o
);
    // Hold the enable mask, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) en_o <= '0;
        else if (wr_i) en_o <= data_i;
    end
endmodule

// File: rtl/vbl_status_bank.sv
// Sticky status bits. Each bit is set by set_i. Bits selected in CLR_MASK
// can also be cleared by a write-one-to-clear; the other bits get no clear
// logic at all. A set in the same cycle as a clear wins.
// Assumes clr_wr_i is already decoded for the status register.
module vbl_status_bank #(
    parameter int           W        = 32,
    parameter logic [W-1:0] CLR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] nxt;

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (CLR_MASK[b]) begin : g_clearable
            // Clearable bit: set has priority over the clear write.
            assign nxt[b] = set_i[b] | (status_o[b] & ~(clr_wr_i & clr_data_i[b]));
        end else begin : g_sticky
            // Non-clearable bit: only reset returns it to zero.
            assign nxt[b] = set_i[b] | status_o[b];
        end
    end

    // Status storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else status_o <= nxt;
    end
endmodule

// File: rtl/vbl_irq_ctrl.sv
// Interrupt controller top: enable and status registers, the vertical-blank
// period source and the level interrupt. An enable write with the vblank bit
// set restarts the period and marks vblank at once. A write with it clear
// halts the period. Reads are combinational and free of side effects.
// Assumes wr_en is a one-cycle strobe per write and evt_i carries pulses.
module vbl_irq_ctrl #(
    parameter int              W        = 32,
    parameter int              PERIOD   = 1_666_667,
    parameter logic [W-1:0]    CLR_MASK = W'(32'h000F_040F)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         rd_sel,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] evt_i,
    output logic         irq_o
);
    import vbl_irq_pkg::*;

    logic         wr_enable_reg;
    logic         wr_status_reg;
    logic         vbl_start;
    logic         vbl_stop;
    logic         vbl_tick;
    logic [W-1:0] set_vec;
    logic [W-1:0] en_q;
    logic [W-1:0] status_q;

    // Decode the write strobe into per-register writes.
    assign wr_enable_reg = wr_en && (reg_sel_e'(wr_sel) == SEL_ENABLE);
    assign wr_status_reg = wr_en && (reg_sel_e'(wr_sel) == SEL_STATUS);
    assign vbl_start     = wr_enable_reg &&  wr_data[VBL_BIT];
    assign vbl_stop      = wr_enable_reg && !wr_data[VBL_BIT];

    // Merge the vblank sources into the event vector.
    always_comb begin
        set_vec          = evt_i;
        set_vec[VBL_BIT] = evt_i[VBL_BIT] | vbl_tick | vbl_start;
    end

    vbl_period_timer #(.PERIOD(PERIOD)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (vbl_start),
        .stop_i  (vbl_stop),
        .tick_o  (vbl_tick)
    );

    vbl_enable_reg #(.W(W)) enable_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_enable_reg),
        .data_i (wr_data),
        .en_o   (en_q)
    );

    vbl_status_bank #(.W(W), .CLR_MASK(CLR_MASK)) status_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .clr_wr_i   (wr_status_reg),
        .clr_data_i (wr_data),
        .status_o   (status_q)
    );

    // Read mux and level interrupt from the registered state.
    assign rd_data = (reg_sel_e'(rd_sel) == SEL_STATUS) ? status_q : en_q;
    assign irq_o   = |(status_q & en_q);
endmodule

// File: rtl/vbl_irq_ctrl_chk.sv
// Protocol checker for vbl_irq_ctrl, attached through bind.
// Assumes the reset is held for at least one clock edge at start-up.
module vbl_irq_ctrl_chk #(
    parameter int           W        = 32,
    parameter logic [W-1:0] CLR_MASK = '1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         wr_sel,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] evt_i,
    input logic [W-1:0] en_q,
    input logic [W-1:0] status_q,
    input logic         vbl_tick,
    input logic         irq_o
);
    // R1: a reset edge leaves both registers clear and the line low.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && status_q == '0 && !irq_o));

    // R3: the enable register takes the written word.
    assert_enable_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (en_q == $past(wr_data)));

    // R4: enabling vblank raises its status and the line next cycle.
    assert_vbl_enable_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[0]) |=> (status_q[0] && irq_o));

    // R6: with vblank disabled and nothing setting it, bit 0 stays low.
    assert_halted_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[0] && !status_q[0] && !evt_i[0] && !(wr_en && !wr_sel && wr_data[0]))
        |=> !status_q[0]);

    // R7: bits outside the clear mask never fall.
    assert_unmasked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) | ~$past(status_q)) != '0 || $past(status_q) == '0)
        |-> (($past(status_q) & ~status_q & ~CLR_MASK) == '0));

    // R8: every event pulse leaves its status bit set.
    assert_event_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> (($past(evt_i) & ~status_q) == '0));

    // R9: a period expiry sets bit 0 even against a clearing write.
    assert_tick_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vbl_tick |=> status_q[0]);
endmodule

bind vbl_irq_ctrl vbl_irq_ctrl_chk #(.W(W), .CLR_MASK(CLR_MASK)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .evt_i    (evt_i),
    .en_q     (en_q),
    .status_q (status_q),
    .vbl_tick (vbl_tick),
    .irq_o    (irq_o)
);

// File: tb/vbl_irq_ctrl_tb_top.sv
// Bench: behavioural reference model compared every clock, plus directed
// scenarios for each requirement.
module vbl_irq_ctrl_tb_top;
    localparam int          W    = 32;
    localparam int          P    = 40;
    localparam logic [31:0] MASK = 32'h000F_040F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic        rd_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] evt = '0;
    logic [31:0] rd_data;
    logic        irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string req = "R1";

    always #5 clk = ~clk;

    vbl_irq_ctrl #(.W(W), .PERIOD(P), .CLR_MASK(MASK)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .evt_i   (evt),
        .irq_o   (irq)
    );

    // Reference model state.
    logic [31:0] m_en = '0;
    logic [31:0] m_st = '0;
    bit          m_run = 1'b0;
    int          m_cnt = 0;

    always @(posedge clk) begin : ref_model
        logic [31:0] setv;
        logic [31:0] clrv;
        bit          restart;
        bit          halt;
        if (!rst_n) begin
            m_en = '0; m_st = '0; m_run = 1'b0; m_cnt = 0;
        end else begin
            restart = wr_en && !wr_sel && wr_data[0];
            halt    = wr_en && !wr_sel && !wr_data[0];
            setv    = evt;
            if (m_run && m_cnt == P - 1) setv[0] = 1'b1;
            if (restart) setv[0] = 1'b1;
            clrv = (wr_en && wr_sel) ? (wr_data & MASK) : '0;
            m_st = (m_st & ~clrv) | setv;
            if (wr_en && !wr_sel) m_en = wr_data;
            if (restart) begin m_run = 1'b1; m_cnt = 0; end
            else if (halt) begin m_run = 1'b0; m_cnt = 0; end
            else if (m_run) m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
        end
    end

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Per-clock comparison, sampled late in the cycle.
    always @(posedge clk) begin
        #7;
        if (rst_n && !done) begin
            check({req, " model rd_data"}, rd_data, rd_sel ? m_st : m_en);
            check({req, " model irq (R2)"}, {31'b0, irq}, {31'b0, |(m_st & m_en)});
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    function automatic logic [31:0] peek(input logic sel);
        rd_sel = sel;
        return rd_data;
    endfunction

    task automatic rd(input logic sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic write_reg(input logic sel, input logic [31:0] d);
        wr_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [31:0] e);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic measure_gap(output int n);
        logic [31:0] v;
        n = 0;
        rd(1'b1, v);
        while (v[0] == 1'b0 && n < 10 * P) begin
            @(negedge clk);
            n++;
            rd(1'b1, v);
        end
    endtask

    initial begin
        logic [31:0] v;
        int gap;
        repeat (3) @(negedge clk);
        // R1: reset values
        rd(1'b0, v); check("R1 enable after reset", v, 32'h0);
        rd(1'b1, v); check("R1 status after reset", v, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        repeat (3 * P) @(negedge clk);
        rd(1'b1, v); check("R1 counter idle after reset", v, 32'h0);

        // R3: enable write without vblank
        req = "R3";
        write_reg(1'b0, 32'h0000_0F06);
        rd(1'b0, v); check("R3 enable readback", v, 32'h0000_0F06);

        // R8 / R2: event pulses on enabled bits
        req = "R8";
        pulse(32'h0000_0300);
        rd(1'b1, v); check("R8 event bits stick", v, 32'h0000_0300);
        check("R2 irq from enabled event", {31'b0, irq}, 32'h1);

        // R7: masked clearing
        req = "R7";
        write_reg(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, v); check("R7 bits outside mask kept", v, 32'h0000_0300);
        pulse(32'h0000_0406);
        write_reg(1'b1, 32'h0000_0004);
        rd(1'b1, v); check("R7 single masked bit cleared", v, 32'h0000_0702);
        write_reg(1'b1, 32'h0000_0402);
        rd(1'b1, v); check("R7 two masked bits cleared", v, 32'h0000_0300);

        // R2: line follows status AND enable
        req = "R2";
        write_reg(1'b0, 32'h0000_0006);
        check("R2 irq low with disabled status", {31'b0, irq}, 32'h0);
        pulse(32'h0000_0002);
        check("R2 irq high on enabled bit", {31'b0, irq}, 32'h1);
        write_reg(1'b1, 32'h0000_0002);
        check("R2 irq low after clear", {31'b0, irq}, 32'h0);

        // R4: enabling vblank marks it at once
        req = "R4";
        write_reg(1'b0, 32'h0000_0001);
        rd(1'b1, v); check("R4 vblank status set", v & 32'h1, 32'h1);
        check("R4 irq raised", {31'b0, irq}, 32'h1);

        // R5: period length and restart phase
        req = "R5";
        write_reg(1'b1, 32'h1);
        measure_gap(gap);
        check("R5 first period", gap, P - 1);
        write_reg(1'b1, 32'h1);
        measure_gap(gap);
        check("R5 repeated period", gap, P - 1);
        repeat (P / 2) @(negedge clk);
        write_reg(1'b0, 32'h1);
        write_reg(1'b1, 32'h1);
        measure_gap(gap);
        check("R5 restart resets phase", gap, P - 1);

        // R9: clearing write in the expiry cycle; event against clear
        req = "R9";
        repeat (P - 1) @(negedge clk);
        write_reg(1'b1, 32'h1);
        rd(1'b1, v); check("R9 expiry beats clear", v & 32'h1, 32'h1);
        wr_sel = 1'b1; wr_data = 32'h2; wr_en = 1'b1; evt = 32'h2;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; evt = '0;
        rd(1'b1, v); check("R9 event beats clear", v & 32'h2, 32'h2);

        // R6: disable halts the counter
        req = "R6";
        write_reg(1'b0, 32'h0);
        write_reg(1'b1, 32'hFFFF_FFFF);
        repeat (3 * P) @(negedge clk);
        rd(1'b1, v); check("R6 no vblank after disable", v, 32'h0000_0300);
        check("R6 irq low", {31'b0, irq}, 32'h0);

        // R10: reads do not disturb state
        req = "R10";
        for (int i = 0; i < 20; i++) begin
            rd(i[0], v);
            @(negedge clk);
        end
        rd(1'b1, v); check("R10 status after reads", v, 32'h0000_0300);
        rd(1'b0, v); check("R10 enable after reads", v, 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule